// File: doc/BRIEF.md
# Integer Multiply Unit

This block is the multiply stage of a small integer core. It takes two operands and a two-bit operation code, and it forms the full double-width product. It then returns either the low word or the high word of that product. For the high word, the operation code decides separately for each operand whether it counts as signed or unsigned. This gives the mixed signed-by-unsigned high product as well as the fully signed and fully unsigned ones.

Work begins with a one-cycle `start` request and ends with a one-cycle `done` pulse. `result` then holds its value until the next accepted request. Internally the operands are reduced to unsigned magnitudes plus one negate flag. A parameter chooses the engine that multiplies the magnitudes. One engine is a single-cycle array product. The other is a shift-and-add loop that handles one multiplier bit per cycle. A shared output stage restores the sign and selects the half to return.

Top module: `imul_unit`

## Requirements
- R1: Operation code 2'b00 returns bits W-1:0 of the product. These bits are the same whether the operands are read as signed or unsigned (for W=32, -1 times -1 gives 1, and 25252566 times 5225225 gives 353909638).
- R2: Operation code 2'b01 reads both operands as signed and returns bits 2W-1:W of the product. For W=32, -1 times -1 gives 0 and 4 times 4 gives 0.
- R3: Operation code 2'b10 reads `opa` as signed and `opb` as unsigned, and returns bits 2W-1:W of the product.
- R4: Operation code 2'b11 reads both operands as unsigned and returns bits 2W-1:W. For W=32, 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE. Both R2 and R4 give 30722 for 25252566 times 5225225.
- R5: `done` is high for exactly one cycle per accepted request. The cycle in which it rises is one clock edge after the edge that sampled `start` for the array engine (ARCH=0), and W edges after it for the shift-and-add engine (ARCH=1).
- R6: `result` does not change except in a cycle where `done` is high. It keeps its value after the pulse until a later request completes.
- R7: A `start` seen while a request is in progress is ignored. The running request completes with its own operands and latency, and no extra `done` pulse follows.
- R8: After reset `done` is low, `result` is zero and the unit is idle.
- R9: Both engine variants give identical results for every operation code and operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted when the unit is idle |
| op | input | 2 | Operation code (see R1-R4 encodings) |
| opa | input | W | First operand, captured on acceptance |
| opb | input | W | Second operand, captured on acceptance |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Selected product half, held until the next completion |

## Verification
The assertions assume that reset is applied before the first request. They also assume that `start` is the only input whose timing matters, since operands and operation code are captured at the accepting edge and need not stay stable afterwards. The bench drives `start` as a one-cycle pulse in normal use. It also deliberately holds a second pulse inside a busy window, so that the ignore rule is exercised rather than assumed. Operands change freely between requests, and a small-width pair of the two engines is swept over every operand pair and operation code.

// File: rtl/imul_pkg.sv
package imul_pkg;

   typedef enum logic [1:0] {
      MOP_LOW   = 2'b00,
      MOP_HI_SS = 2'b01,
      MOP_HI_SU = 2'b10,
      MOP_HI_UU = 2'b11
   } mop_e;

   localparam int ARCH_ARRAY  = 0;
   localparam int ARCH_SERIAL = 1;

   function automatic logic mop_a_signed(mop_e m);
      return (m == MOP_HI_SS) || (m == MOP_HI_SU);
   endfunction

   function automatic logic mop_b_signed(mop_e m);
      return (m == MOP_HI_SS);
   endfunction

endpackage

// File: rtl/imul_opprep.sv
module imul_opprep
   import imul_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  mop_e         mop,
   output logic [W-1:0] mag_a,
   output logic [W-1:0] mag_b,
   output logic         neg,
   output logic         want_hi
);
   logic a_neg, b_neg;

   always_comb begin
      a_neg   = mop_a_signed(mop) && a_in[W-1];
      b_neg   = mop_b_signed(mop) && b_in[W-1];
      mag_a   = a_neg ? (~a_in + W'(1)) : a_in;
      mag_b   = b_neg ? (~b_in + W'(1)) : b_in;
      neg     = a_neg ^ b_neg;
      want_hi = (mop != MOP_LOW);
   end
endmodule

// File: rtl/imul_eng_array.sv
module imul_eng_array #(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [W-1:0]   mag_a,
   input  logic [W-1:0]   mag_b,
   output logic           fin,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2 * W;

   logic [PW-1:0] prod_q;
   logic          fin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q <= '0;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= load;
         if (load) prod_q <= {{W{1'b0}}, mag_a} * {{W{1'b0}}, mag_b};
      end
   end

   assign fin  = fin_q;
   assign prod = prod_q;

   assert_array_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> fin);
   assert_array_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);
endmodule

// File: rtl/imul_eng_serial.sv
module imul_eng_serial #(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [W-1:0]   mag_a,
   input  logic [W-1:0]   mag_b,
   output logic           fin,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2 * W;
   localparam int CW = $clog2(W + 1);

   logic [PW-1:0] acc_q, mc_q, acc_nxt;
   logic [W-1:0]  mp_q;
   logic [CW-1:0] cnt_q;
   logic          active_q;

   always_comb begin
      acc_nxt = acc_q + (mp_q[0] ? mc_q : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         mc_q     <= '0;
         mp_q     <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (load) begin
         acc_q    <= '0;
         mc_q     <= {{W{1'b0}}, mag_a};
         mp_q     <= mag_b;
         cnt_q    <= '0;
         active_q <= 1'b1;
      end else if (active_q) begin
         acc_q <= acc_nxt;
         mc_q  <= mc_q << 1;
         mp_q  <= mp_q >> 1;
         cnt_q <= cnt_q + CW'(1);
         if (fin) active_q <= 1'b0;
      end
   end

   assign fin  = active_q && (cnt_q == CW'(W - 1));
   assign prod = acc_nxt;

   assert_no_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !active_q);
   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (cnt_q < CW'(W)));
   assert_serial_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);
endmodule

// File: rtl/imul_fold.sv
module imul_fold #(
   parameter int W = 32
) (
   input  logic [2*W-1:0] prod,
   input  logic           neg,
   input  logic           want_hi,
   output logic [W-1:0]   res
);
   logic [2*W-1:0] signed_prod;

   always_comb begin
      signed_prod = neg ? (~prod + (2*W)'(1)) : prod;
      res         = want_hi ? signed_prod[2*W-1:W] : signed_prod[W-1:0];
   end
endmodule

// File: rtl/imul_unit.sv
module imul_unit
   import imul_pkg::*;
#(
   parameter int W    = 32,
   parameter int ARCH = ARCH_ARRAY
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [1:0]   op,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output logic         done,
   output logic [W-1:0] result
);
   localparam int PW = 2 * W;

   if (W < 2) begin : g_bad_width
      $error("imul_unit: W must be at least 2");
   end
   if (ARCH != ARCH_ARRAY && ARCH != ARCH_SERIAL) begin : g_bad_arch
      $error("imul_unit: ARCH must select the array or the serial engine");
   end

   logic          busy_q, neg_q, hi_q, done_q;
   logic [W-1:0]  res_q, folded, mag_a, mag_b;
   logic          neg_d, hi_d, load, fin;
   logic [PW-1:0] prod;

   assign load = start && !busy_q;

   imul_opprep #(.W(W)) u_prep (
      .a_in   (opa),
      .b_in   (opb),
      .mop    (mop_e'(op)),
      .mag_a  (mag_a),
      .mag_b  (mag_b),
      .neg    (neg_d),
      .want_hi(hi_d)
   );

   if (ARCH == ARCH_SERIAL) begin : g_serial
      imul_eng_serial #(.W(W)) u_eng (
         .clk(clk), .rst_n(rst_n), .load(load),
         .mag_a(mag_a), .mag_b(mag_b), .fin(fin), .prod(prod)
      );
   end else begin : g_array
      imul_eng_array #(.W(W)) u_eng (
         .clk(clk), .rst_n(rst_n), .load(load),
         .mag_a(mag_a), .mag_b(mag_b), .fin(fin), .prod(prod)
      );
   end

   imul_fold #(.W(W)) u_fold (
      .prod   (prod),
      .neg    (neg_q),
      .want_hi(hi_q),
      .res    (folded)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         neg_q  <= 1'b0;
         hi_q   <= 1'b0;
         done_q <= 1'b0;
         res_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            busy_q <= 1'b1;
            neg_q  <= neg_d;
            hi_q   <= hi_d;
         end
         if (fin) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            res_q  <= folded;
         end
      end
   end

   assign done   = done_q;
   assign result = res_q;

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);
   assert_fin_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> busy_q);
   assert_load_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy_q);
endmodule

// File: tb/sim_imul_unit.sv
module sim_imul_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WS = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   n_run = 0, n_fail = 0;

   logic        s0_start = 1'b0;
   logic [1:0]  s0_op = 2'b00;
   logic [31:0] s0_a = '0, s0_b = '0;
   logic        d0_done;
   logic [31:0] d0_res;

   logic          sm_start = 1'b0;
   logic [1:0]    sm_op = 2'b00;
   logic [WS-1:0] sm_a = '0, sm_b = '0;
   logic          f_done, q_done;
   logic [WS-1:0] f_res, q_res;

   always #(CLK_PERIOD/2) clk = ~clk;

   imul_unit #(.W(32), .ARCH(1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(s0_start), .op(s0_op),
      .opa(s0_a), .opb(s0_b), .done(d0_done), .result(d0_res));
   imul_unit #(.W(WS), .ARCH(0)) u1 (
      .clk(clk), .rst_n(rst_n), .start(sm_start), .op(sm_op),
      .opa(sm_a), .opb(sm_b), .done(f_done), .result(f_res));
   imul_unit #(.W(WS), .ARCH(1)) u2 (
      .clk(clk), .rst_n(rst_n), .start(sm_start), .op(sm_op),
      .opa(sm_a), .opb(sm_b), .done(q_done), .result(q_res));

   function automatic logic [63:0] model(int w, logic [1:0] o, logic [63:0] a, logic [63:0] b);
      logic [63:0] mask, ea, eb, p;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      ea = ((o == 2'b01 || o == 2'b10) && a[w-1]) ? (a | ~mask) : (a & mask);
      eb = ((o == 2'b01) && b[w-1]) ? (b | ~mask) : (b & mask);
      p  = ea * eb;
      return (o == 2'b00) ? (p & mask) : ((p >> w) & mask);
   endfunction

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(logic [1:0] o);
      case (o)
         2'b00: return "R1";
         2'b01: return "R2";
         2'b10: return "R3";
         default: return "R4";
      endcase
   endfunction

   // one request on the 32-bit serial unit; optional stray start while busy (R7)
   task automatic run_big(logic [1:0] o, logic [31:0] a, logic [31:0] b, bit stray);
      int lat = 0, pulses = 0, got_lat = -1;
      logic [31:0] exp, got;
      exp = 32'(model(32, o, {32'd0, a}, {32'd0, b}));
      @(negedge clk);
      s0_op = o; s0_a = a; s0_b = b; s0_start = 1'b1;
      @(negedge clk);
      s0_start = 1'b0;
      s0_a = ~a; s0_b = b + 32'd7; s0_op = ~o;
      for (int i = 0; i < 80; i++) begin
         if (stray && lat == 3) s0_start = 1'b1;
         if (stray && lat == 4) s0_start = 1'b0;
         @(negedge clk);
         lat++;
         if (d0_done) begin
            pulses++;
            if (got_lat < 0) begin got_lat = lat; got = d0_res; end
         end
      end
      chk(got_lat == 32, "R5", "serial latency", 64'(got_lat), 64'd32);
      chk(pulses == 1, stray ? "R7" : "R5", "done pulse count", 64'(pulses), 64'd1);
      chk(got == exp, stray ? "R7" : req_of(o), "32-bit result", {32'd0, got}, {32'd0, exp});
      chk(d0_res == exp, "R6", "32-bit result held", {32'd0, d0_res}, {32'd0, exp});
   endtask

   // one request on both small units at once (R9 compares the engines)
   task automatic run_small(logic [1:0] o, logic [WS-1:0] a, logic [WS-1:0] b);
      int lat = 0, lf = -1, lq = -1, pf = 0, pq = 0;
      logic [WS-1:0] exp, rf, rq;
      exp = WS'(model(WS, o, 64'(a), 64'(b)));
      @(negedge clk);
      sm_op = o; sm_a = a; sm_b = b; sm_start = 1'b1;
      @(negedge clk);
      sm_start = 1'b0;
      sm_a = ~a; sm_b = ~b;
      for (int i = 0; i < WS + 2; i++) begin
         @(negedge clk);
         lat++;
         if (f_done) begin pf++; if (lf < 0) begin lf = lat; rf = f_res; end end
         if (q_done) begin pq++; if (lq < 0) begin lq = lat; rq = q_res; end end
      end
      chk(rf == exp, req_of(o), "array result", 64'(rf), 64'(exp));
      chk(rq == rf, "R9", "serial vs array", 64'(rq), 64'(rf));
      chk(lf == 1 && pf == 1, "R5", "array latency/pulses", 64'(lf * 100 + pf), 64'd101);
      chk(lq == WS && pq == 1, "R5", "serial latency/pulses", 64'(lq * 100 + pq), 64'(WS * 100 + 1));
      chk(f_res == exp, "R6", "array result held", 64'(f_res), 64'(exp));
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(d0_done == 1'b0 && f_done == 1'b0 && q_done == 1'b0, "R8", "done in reset", 64'(d0_done), 64'd0);
      chk(d0_res == '0 && f_res == '0 && q_res == '0, "R8", "result in reset", 64'(d0_res), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(d0_done == 1'b0, "R8", "done after reset", 64'(d0_done), 64'd0);

      run_big(2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);   // R1: 1
      run_big(2'b00, 32'd25252566, 32'd5225225, 1'b0);    // R1: 353909638
      run_big(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);   // R2: 0
      run_big(2'b01, 32'd4, 32'd4, 1'b0);                 // R2
      run_big(2'b01, 32'd25252566, 32'd5225225, 1'b0);    // R2: 30722
      run_big(2'b11, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);   // R4: 0xFFFFFFFE
      run_big(2'b11, 32'd25252566, 32'd5225225, 1'b0);    // R4: 30722
      run_big(2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);   // R3
      run_big(2'b10, 32'h80000000, 32'h80000000, 1'b0);   // R3
      run_big(2'b01, 32'h80000000, 32'h80000000, 1'b0);   // R2
      run_big(2'b10, 32'h00001234, 32'hF0000001, 1'b0);   // R3
      run_big(2'b11, 32'h12345678, 32'h9ABCDEF0, 1'b1);   // R7 stray start

      for (int o = 0; o < 4; o++)
         for (int a = 0; a < (1 << WS); a++)
            for (int b = 0; b < (1 << WS); b++)
               run_small(2'(o), WS'(a), WS'(b));

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule